// File: doc/BRIEF.md
# Column Hit-Pattern Encoder

This block reduces the binary hit map of one 128-channel pixel column to a single 10-bit word that describes one narrow-cluster candidate. The channels are split into contiguous groups of four. For each group the block checks whether the group holds a narrow cluster. A cluster counts as wide when its run of adjacent hit channels is three or more long. Runs are traced across group boundaries, and at the top of the column they continue through an edge-neighbour input that stands for the first channel of the next chip up.

On each strobed crossing the encoder reports the lowest-numbered candidate group. The word gives the group address, the group's own four hit bits, and a flag that is set when the reported cluster reaches the last channel of the column. A downstream correlator then knows that the cluster may continue beyond the chip. When a crossing holds more than one candidate, the extra candidates are dropped and a saturating counter records the event. The output is registered and appears one clock after the strobe.

Top module: `colhit_encoder`

## Requirements
- R1: One clock after a cycle with `in_valid` high, if that cycle's hit vector contains a candidate, `word_valid` is high for one cycle. `word[9:5]` then holds the group index g, and `word[4:1]` holds `hits[4g+3:4g]`, where word bit 1+i is channel 4g+i.
- R2: A group is rejected when any of its hit channels lies in a run of three or more consecutive hit channels. The run is traced across group boundaries, and `edge_nbr` acts as channel 128 above channel 127. As a result, 0111, 1110 and 1111 are never reported. The patterns 1011, 1101, 1001, 0101 and 1010 are accepted when nothing outside the group extends them.
- R3: A group is a candidate only if a cluster starts inside it, meaning it has a hit channel whose next lower channel is not hit. A two-channel cluster that straddles a boundary therefore belongs to the lower group. An upper group that holds only the continuation of that cluster is not a candidate.
- R4: When several groups are candidates, the one with the lowest index is reported.
- R5: `ovf_count` increases by exactly one, one clock after a strobed vector that holds two or more candidate groups. It saturates at its all-ones value.
- R6: `word[0]` is 1 exactly when the reported group is the top group (31) and channel 127 is hit. This holds whatever the state of `edge_nbr`, provided the group is accepted.
- R7: When the strobe was low, or the strobed vector had no candidate, `word_valid` is 0 and `word` is all zeros in the following cycle, and `ovf_count` does not change.
- R8: While `rst_n` is low and after its release, `word_valid`, `word` and `ovf_count` are all zero until the first strobe is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Hit vector is latched and should be encoded this cycle |
| hits | input | 128 | Binary hit map, bit c is channel c |
| edge_nbr | input | 1 | Hit state of the channel just above channel 127 on the next chip |
| word_valid | output | 1 | Encoded word holds a candidate |
| word | output | 10 | {group address[4:0], pattern[3:0], top-edge flag} |
| ovf_count | output | 8 | Saturating count of crossings with more than one candidate |

## Verification
Every result, whether the word, its valid strobe or the overflow count step, is due exactly one clock after the cycle in which the strobe and the hit vector were presented. The driver presents each vector at a falling edge and files the expected item just after the next rising edge. The monitor compares that item at the following falling edge, so each comparison lands in the single cycle where the registered output reflects its vector. Idle and unstrobed cycles are filed too, so an early or lingering valid is caught as a miscompare.

// File: rtl/colhit_pkg.sv
package colhit_pkg;
    localparam int COL_CH_DEF   = 128;
    localparam int COL_GRP_DEF  = 4;
    localparam int COL_CNT_DEF  = 8;

    // True when a w-bit pattern holds no run of three adjacent ones
    function automatic logic no_run3(input logic [31:0] v, input int w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i + 2 < w; i++) begin
            if (v[i] && v[i+1] && v[i+2]) ok = 1'b0;
        end
        return ok;
    endfunction
endpackage

// File: rtl/colhit_run_mask.sv
module colhit_run_mask #(
    parameter int N_CH = 128
) (
    input  logic [N_CH-1:0] hits,
    input  logic            edge_nbr,
    output logic [N_CH-1:0] wide,
    output logic [N_CH-1:0] start
);
    localparam int XW = N_CH + 4;

    // Two zero pads below channel 0, neighbour and a zero pad above the top
    logic [XW-1:0] x;
    assign x = {1'b0, edge_nbr, hits, 2'b00};

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam int K = c + 2;
        assign wide[c]  = x[K] & ((x[K-1] & x[K-2]) |
                                  (x[K-1] & x[K+1]) |
                                  (x[K+1] & x[K+2]));
        assign start[c] = x[K] & ~x[K-1];
    end
endmodule

// File: rtl/colhit_group_eval.sv
module colhit_group_eval #(
    parameter int N_CH  = 128,
    parameter int GRP_W = 4,
    localparam int N_GRP = N_CH / GRP_W
) (
    input  logic [N_CH-1:0]  wide,
    input  logic [N_CH-1:0]  start,
    output logic [N_GRP-1:0] cand
);
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic owns_cluster;
        logic touches_wide;
        assign owns_cluster = |start[g*GRP_W +: GRP_W];
        assign touches_wide = |wide[g*GRP_W +: GRP_W];
        assign cand[g]      = owns_cluster & ~touches_wide;
    end
endmodule

// File: rtl/colhit_pick.sv
module colhit_pick #(
    parameter int N_GRP = 32,
    localparam int ADDR_W = $clog2(N_GRP)
) (
    input  logic [N_GRP-1:0]  cand,
    output logic              found,
    output logic [ADDR_W-1:0] idx,
    output logic              multi
);
    always_comb begin
        logic seen;
        idx   = '0;
        seen  = 1'b0;
        multi = 1'b0;
        for (int i = N_GRP - 1; i >= 0; i--) begin
            if (cand[i]) idx = ADDR_W'(i);
        end
        for (int i = 0; i < N_GRP; i++) begin
            if (cand[i] && seen) multi = 1'b1;
            if (cand[i]) seen = 1'b1;
        end
        found = |cand;
    end
endmodule

// File: rtl/colhit_encoder.sv
module colhit_encoder
    import colhit_pkg::*;
#(
    parameter int N_CH  = COL_CH_DEF,
    parameter int GRP_W = COL_GRP_DEF,
    parameter int CNT_W = COL_CNT_DEF,
    localparam int N_GRP  = N_CH / GRP_W,
    localparam int ADDR_W = $clog2(N_GRP),
    localparam int WORD_W = ADDR_W + GRP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [N_CH-1:0]   hits,
    input  logic              edge_nbr,
    output logic              word_valid,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  ovf_count
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [GRP_W-1:0]  pat;
        logic              spare;
        logic [CNT_W-1:0]  ovf;
    } enc_state_t;

    logic [N_CH-1:0]   wide_m;
    logic [N_CH-1:0]   start_m;
    logic [N_GRP-1:0]  cand;
    logic              pick_found;
    logic [ADDR_W-1:0] pick_idx;
    logic              pick_multi;

    enc_state_t st_d, st_q;

    colhit_run_mask #(.N_CH(N_CH)) u_runs (
        .hits     (hits),
        .edge_nbr (edge_nbr),
        .wide     (wide_m),
        .start    (start_m)
    );

    colhit_group_eval #(.N_CH(N_CH), .GRP_W(GRP_W)) u_groups (
        .wide  (wide_m),
        .start (start_m),
        .cand  (cand)
    );

    colhit_pick #(.N_GRP(N_GRP)) u_pick (
        .cand  (cand),
        .found (pick_found),
        .idx   (pick_idx),
        .multi (pick_multi)
    );

    always_comb begin
        logic [GRP_W-1:0] sel_pat;
        sel_pat     = GRP_W'(hits >> (int'(pick_idx) * GRP_W));
        st_d        = st_q;
        st_d.vld    = 1'b0;
        st_d.addr   = '0;
        st_d.pat    = '0;
        st_d.spare  = 1'b0;
        if (in_valid && pick_found) begin
            st_d.vld   = 1'b1;
            st_d.addr  = pick_idx;
            st_d.pat   = sel_pat;
            st_d.spare = (pick_idx == ADDR_W'(N_GRP - 1)) && sel_pat[GRP_W-1];
        end
        if (in_valid && pick_multi && (st_q.ovf != {CNT_W{1'b1}})) begin
            st_d.ovf = st_q.ovf + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_valid = st_q.vld;
    assign word       = {st_q.addr, st_q.pat, st_q.spare};
    assign ovf_count  = st_q.ovf;
endmodule

// File: rtl/colhit_checker.sv
module colhit_checker
    import colhit_pkg::*;
#(
    parameter int N_CH  = 128,
    parameter int GRP_W = 4,
    parameter int CNT_W = 8,
    localparam int N_GRP  = N_CH / GRP_W,
    localparam int ADDR_W = $clog2(N_GRP),
    localparam int WORD_W = ADDR_W + GRP_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [N_CH-1:0]   hits,
    input logic              word_valid,
    input logic [WORD_W-1:0] word,
    input logic [CNT_W-1:0]  ovf_count
);
    logic [ADDR_W-1:0] addr_f;
    logic [GRP_W-1:0]  pat_f;
    logic              narrow_f;
    assign addr_f   = word[WORD_W-1 -: ADDR_W];
    assign pat_f    = word[GRP_W:1];
    assign narrow_f = no_run3(32'(pat_f), GRP_W);

    AST_PAT_FROM_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> pat_f == GRP_W'($past(hits) >> (int'(addr_f) * GRP_W))); // R1

    AST_PAT_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (pat_f != '0) && narrow_f); // R2

    AST_EDGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word[0]) |-> (addr_f == ADDR_W'(N_GRP - 1)) && pat_f[GRP_W-1]); // R6

    AST_NO_STROBE_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !word_valid); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> word == '0); // R7

    AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_count != $past(ovf_count)) |->
            (ovf_count == $past(ovf_count) + 1'b1) && $past(in_valid)); // R5
endmodule

bind colhit_encoder colhit_checker #(
    .N_CH (N_CH),
    .GRP_W(GRP_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .hits      (hits),
    .word_valid(word_valid),
    .word      (word),
    .ovf_count (ovf_count)
);

// File: tb/sim_colhit_encoder.sv
module sim_colhit_encoder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] hits = '0;
    logic         edge_nbr = 1'b0;
    logic         word_valid;
    logic [9:0]   word;
    logic [7:0]   ovf_count;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_ovf  = 0;
    bit finished = 0;

    typedef struct {
        logic       vld;
        logic [9:0] w;
        logic [7:0] ovf;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    colhit_encoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .hits      (hits),
        .edge_nbr  (edge_nbr),
        .word_valid(word_valid),
        .word      (word),
        .ovf_count (ovf_count)
    );

    // Independent model: trace runs explicitly, then judge each group
    task automatic predict(input logic [127:0] h, input logic nb, input logic v,
                           input string tag);
        logic [129:0] e;
        logic [129:0] wd;
        logic [129:0] st;
        int c, s, len, first, ncand;
        exp_t x;
        e = {1'b0, nb, h};
        wd = '0; st = '0;
        c = 0;
        while (c < 130) begin
            if (e[c]) begin
                s = c; len = 0;
                while (c < 130 && e[c]) begin c++; len++; end
                st[s] = 1'b1;
                if (len >= 3) for (int j = s; j < c; j++) wd[j] = 1'b1;
            end else c++;
        end
        first = -1; ncand = 0;
        for (int g = 0; g < 32; g++) begin
            logic has, bad;
            has = 1'b0; bad = 1'b0;
            for (int i = 0; i < 4; i++) begin
                has |= st[4*g+i];
                bad |= wd[4*g+i];
            end
            if (has && !bad) begin
                ncand++;
                if (first < 0) first = g;
            end
        end
        x.tag = tag;
        if (v && ncand > 1 && exp_ovf < 255) exp_ovf++;
        x.ovf = 8'(exp_ovf);
        if (v && first >= 0) begin
            logic [3:0] p;
            p = h[4*first +: 4];
            x.vld = 1'b1;
            x.w   = {5'(first), p, (first == 31) && p[3]};
        end else begin
            x.vld = 1'b0;
            x.w   = '0;
        end
        sb.push_back(x);
    endtask

    task automatic apply(input logic [127:0] h, input logic nb, input logic v,
                         input string tag);
        @(negedge clk);
        hits = h; edge_nbr = nb; in_valid = v;
        @(posedge clk);
        #1;
        predict(h, nb, v, tag);
    endtask

    function automatic logic [127:0] ch(input int a);
        return 128'(1) << a;
    endfunction

    // Monitor: each expected item is due at the falling edge after it is filed
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            n_checks++;
            if (word_valid !== x.vld || word !== x.w || ovf_count !== x.ovf) begin
                n_fail++;
                $display("FAIL %s: got vld=%b word=%h ovf=%0d, expected vld=%b word=%h ovf=%0d",
                         x.tag, word_valid, word, ovf_count, x.vld, x.w, x.ovf);
            end
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (word_valid !== 1'b0 || word !== '0 || ovf_count !== '0) begin
            n_fail++;
            $display("FAIL R8: got vld=%b word=%h ovf=%0d, expected 0 0 0",
                     word_valid, word, ovf_count);
        end
        @(negedge clk); rst_n = 1'b1;
        apply('0, 1'b0, 1'b0, "R8");

        apply('0, 1'b0, 1'b1, "R7");                           // empty column
        apply(ch(5), 1'b0, 1'b1, "R1");                        // single hit
        apply(ch(0) | ch(1), 1'b0, 1'b1, "R1");                // pair 0011
        apply(128'hB << 28, 1'b0, 1'b1, "R2");                 // 1011 group 7
        apply(128'hD << 40, 1'b0, 1'b1, "R2");                 // 1101 group 10
        apply(128'h9 << 60, 1'b0, 1'b1, "R2");                 // 1001
        apply(128'h5 << 64, 1'b0, 1'b1, "R2");                 // 0101
        apply(128'hA << 72, 1'b0, 1'b1, "R2");                 // 1010
        apply(128'h7 << 12, 1'b0, 1'b1, "R2");                 // 0111 rejected
        apply(128'hE << 16, 1'b0, 1'b1, "R2");                 // 1110 rejected
        apply(128'hF << 20, 1'b0, 1'b1, "R2");                 // 1111 rejected
        apply(ch(7) | ch(8), 1'b0, 1'b1, "R3");                // straddle pair
        apply(ch(7) | ch(8) | ch(9), 1'b0, 1'b1, "R2");        // straddle triple
        apply(ch(7) | ch(8) | ch(9) | ch(38), 1'b0, 1'b1, "R4");
        apply(ch(13) | ch(81), 1'b0, 1'b1, "R4");              // two candidates
        apply(ch(127), 1'b0, 1'b1, "R6");
        apply(ch(127), 1'b1, 1'b1, "R6");                      // pair across chip edge
        apply(ch(126) | ch(127), 1'b1, 1'b1, "R2");            // wide across chip edge
        apply(ch(124), 1'b0, 1'b1, "R6");                      // top group, no edge flag
        apply(ch(33), 1'b0, 1'b0, "R7");                       // strobe low
        apply('0, 1'b0, 1'b0, "R7");

        for (int n = 0; n < 300; n++) begin
            logic [127:0] h;
            h = '0;
            for (int c = 0; c < 128; c++) if ($urandom_range(0, 99) < 3) h[c] = 1'b1;
            apply(h, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) != 0), "R1");
        end
        for (int n = 0; n < 280; n++) apply(ch(1) | ch(100), 1'b0, 1'b1, "R5");
        apply('0, 1'b0, 1'b0, "R5");
        apply('0, 1'b0, 1'b0, "R7");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule